// File: doc/BRIEF.md
# Stack Operation Sequencer

This block carries out one stack command at a time for a processor datapath. It owns the stack pointer register and drives a single word-wide, byte-addressed data memory port. A command is one of push, pop, call or return. It comes with a data or destination operand and, for calls, the address of the following instruction. The sequencer moves the pointer and performs the memory access in the order the stack discipline requires. It then reports the popped word, or the next program counter, on its result output.

The stack grows toward lower addresses, and the pointer always holds the address of the word on top. A push moves the pointer down one word before storing. A pop fetches the top word before moving the pointer up. A call is a push of the return address that also hands back the destination as the next PC. A return is a pop whose word becomes the next PC. The memory answers a read one cycle after the request, and a write completes in the cycle it is issued. A command starts with a one-cycle `start` and ends with a one-cycle `done` pulse.

Top module: `stack_seq`

## Requirements
- R1: While `rst_n` is low and after its release, `sp` equals the parameter `SP_RESET` (default 0x100), `result` is 0, `done` and `err` are 0, and neither `mem_wr` nor `mem_rd` is asserted.
- R2: Command code 00 (push), taken at a `start` edge, first lowers `sp` by 4. In the next cycle it asserts `mem_wr` alone, with `mem_addr` equal to the lowered `sp` and `mem_wdata` equal to `operand`. `result` is left unchanged.
- R3: Command code 01 (pop), taken at a `start` edge, asserts `mem_rd` for one cycle with `mem_addr` equal to the current `sp` while `sp` is unchanged. Two cycles after the request, `result` holds the word read and `sp` has risen by 4.
- R4: Command code 10 (call) writes `ret_addr` to the word below the current top, with the same pointer order and cycle timing as a push. It then sets `result` to `operand`, the destination.
- R5: Command code 11 (return) reads the top word with the same timing as a pop. It sets `result` to that word and raises `sp` by 4. `pop_to_sp` has no effect on it.
- R6: A pop with `pop_to_sp` high leaves the popped word in `sp` in place of the increment, and also returns it on `result`.
- R7: If `sp` is not a multiple of 4 when a command is taken, no memory access happens and `sp` and `result` keep their values. `err` and `done` rise together one cycle after the `start` edge. `err` stays high until the next `start` is taken.
- R8: `done` is high for exactly one cycle: the cycle after the write for push and call, or the cycle after the read data is taken for pop and return. A `start` while a command is in progress is ignored. With no command in progress, `sp` and `result` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Take a command this cycle (ignored while busy) |
| op | input | 2 | Command: 00 push, 01 pop, 10 call, 11 return |
| operand | input | 32 | Push data or call destination |
| ret_addr | input | 32 | Address of the following instruction, stored by call |
| pop_to_sp | input | 1 | Pop destination is the stack pointer itself |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last command was refused for a misaligned pointer |
| result | output | 32 | Popped word, or next PC for call and return |
| sp | output | 32 | Stack pointer |
| mem_addr | output | 32 | Byte address of the word access |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 32 | Write data |
| mem_rd | output | 1 | Read strobe; data is expected on the next cycle |
| mem_rdata | input | 32 | Read data, one cycle after `mem_rd` |

## Verification
The two functions that can land on the pointer in the same cycle are the post-pop increment and the load of the popped word into the pointer. The bench provokes this by pushing a chosen word and then popping with `pop_to_sp` high. It judges the result by checking that `sp` equals the word and not the old pointer plus 4. It then pushes a word that is not a multiple of 4 and pops it into the pointer. Every later command must then be refused with `err`, with no memory strobe. A second overlap is a new `start` arriving during a write cycle. The bench checks that this `start` starts nothing.

// File: rtl/stack_seq.sv
module stack_seq #(
  parameter int W = 32,
  parameter logic [W-1:0] SP_RESET = 'h100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] operand,
  input  logic [W-1:0] ret_addr,
  input  logic         pop_to_sp,
  output logic         done,
  output logic         err,
  output logic [W-1:0] result,
  output logic [W-1:0] sp,
  output logic [W-1:0] mem_addr,
  output logic         mem_wr,
  output logic [W-1:0] mem_wdata,
  output logic         mem_rd,
  input  logic [W-1:0] mem_rdata
);
  localparam int BYTES = W / 8;
  localparam int AB = $clog2(BYTES);
  localparam logic [W-1:0] STEP = W'(BYTES);

  typedef enum logic [1:0] {IDLE, WRITE, READ, TAKE} state_t;
  state_t state;
  logic [1:0] op_q;
  logic to_sp_q;
  logic [W-1:0] dest_q, wdata_q;
  logic busy;

  assign busy = state != IDLE;
  assign mem_addr = sp;
  assign mem_wr = state == WRITE;
  assign mem_rd = state == READ;
  assign mem_wdata = wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= IDLE;
      sp      <= SP_RESET;
      result  <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
      op_q    <= 2'b00;
      to_sp_q <= 1'b0;
      dest_q  <= '0;
      wdata_q <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        IDLE: if (start) begin
          err     <= 1'b0;
          op_q    <= op;
          to_sp_q <= pop_to_sp;
          dest_q  <= operand;
          if (sp[AB-1:0] != '0) begin
            err  <= 1'b1;
            done <= 1'b1;
          end else if (!op[0]) begin
            sp      <= sp - STEP;
            wdata_q <= op[1] ? ret_addr : operand;
            state   <= WRITE;
          end else begin
            state <= READ;
          end
        end
        WRITE: begin
          if (op_q[1]) result <= dest_q;
          done  <= 1'b1;
          state <= IDLE;
        end
        READ: state <= TAKE;
        TAKE: begin
          result <= mem_rdata;
          sp     <= (!op_q[1] && to_sp_q) ? mem_rdata : sp + STEP;
          done   <= 1'b1;
          state  <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

module stack_seq_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         err,
  input logic         mem_wr,
  input logic         mem_rd,
  input logic [W-1:0] sp,
  input logic [W-1:0] result
);
  localparam logic [W-1:0] STEP = W'(W / 8);

  p_push_predec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> sp == $past(sp) - STEP);

  p_pop_read_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> $stable(sp));

  p_err_no_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!mem_wr && !mem_rd));

  p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);

  p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr && mem_rd));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(sp) && $stable(result) && !done));
endmodule

bind stack_seq stack_seq_chk #(.W(W)) u_chk (.*);

// File: tb/stack_seq_test.sv
`timescale 1ns/1ps
module stack_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = 2'b00;
  logic [31:0] operand = '0, ret_addr = '0;
  logic pop_to_sp = 1'b0;
  logic done, err, mem_wr, mem_rd;
  logic [31:0] result, sp, mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  logic [31:0] mem [0:63];
  logic [31:0] exp_mem [0:63];
  logic [31:0] exp_sp = 32'h100, exp_res = '0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  stack_seq uut (.clk, .rst_n, .start, .op, .operand, .ret_addr, .pop_to_sp,
    .done, .err, .result, .sp, .mem_addr, .mem_wr, .mem_wdata, .mem_rd, .mem_rdata);

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[7:2]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[7:2]];
  end

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] o, input logic [31:0] a, input logic [31:0] ra,
                     input logic ts, input string tag, input logic poke = 1'b0);
    logic [31:0] word;
    @(negedge clk);
    start = 1'b1; op = o; operand = a; ret_addr = ra; pop_to_sp = ts;
    @(negedge clk);
    start = 1'b0;
    if (exp_sp[1:0] != 2'b00) begin
      check(done && err, tag, "misaligned done/err", {30'd0, done, err}, 32'd3);
      check(!mem_wr && !mem_rd, tag, "misaligned strobes", {30'd0, mem_wr, mem_rd}, 32'd0);
      check(sp == exp_sp && result == exp_res, tag, "misaligned sp held", sp, exp_sp);
      @(negedge clk);
      check(err && !done, tag, "err held, done single", {30'd0, done, err}, 32'd1);
      return;
    end
    if (!o[0]) begin
      word = o[1] ? ra : a;
      check(mem_wr && !mem_rd, tag, "write strobe", {30'd0, mem_wr, mem_rd}, 32'd2);
      check(mem_addr == exp_sp - 32'd4, tag, "write addr", mem_addr, exp_sp - 32'd4);
      check(mem_wdata == word, tag, "write data", mem_wdata, word);
      check(!done, tag, "no early done", {31'd0, done}, 32'd0);
      exp_sp -= 32'd4;
      exp_mem[exp_sp[7:2]] = word;
      if (o[1]) exp_res = a;
      if (poke) begin start = 1'b1; op = 2'b01; end
      @(negedge clk);
      start = 1'b0;
    end else begin
      check(mem_rd && !mem_wr, tag, "read strobe", {30'd0, mem_wr, mem_rd}, 32'd1);
      check(mem_addr == exp_sp && sp == exp_sp, tag, "read addr before inc", mem_addr, exp_sp);
      word = exp_mem[exp_sp[7:2]];
      @(negedge clk);
      check(!done, tag, "no early done", {31'd0, done}, 32'd0);
      exp_res = word;
      exp_sp = (o == 2'b01 && ts) ? word : exp_sp + 32'd4;
      @(negedge clk);
    end
    check(done && !err, tag, "done pulse", {30'd0, done, err}, 32'd2);
    check(sp == exp_sp, tag, "sp after", sp, exp_sp);
    check(result == exp_res, tag, "result", result, exp_res);
    @(negedge clk);
    check(!done && !mem_rd && !mem_wr, "R8", "quiet after done",
          {29'd0, done, mem_wr, mem_rd}, 32'd0);
    check(sp == exp_sp && result == exp_res, "R8", "hold after done", sp, exp_sp);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin mem[i] = '0; exp_mem[i] = '0; end
    repeat (3) @(negedge clk);
    check(sp == 32'h100 && result == 0 && !done && !err && !mem_wr && !mem_rd,
          "R1", "reset state", sp, 32'h100);
    rst_n = 1'b1;
    @(negedge clk);
    check(sp == 32'h100 && !done && !mem_wr && !mem_rd, "R1", "after release", sp, 32'h100);

    for (int i = 0; i < 8; i++) run(2'b00, 32'h1357_9bdf * (i + 1), '0, 1'b0, "R2");
    for (int i = 0; i < 8; i++) run(2'b01, '0, '0, 1'b0, "R3");
    check(exp_res == 32'h1357_9bdf && sp == 32'h100, "R3", "LIFO bottom", result, 32'h1357_9bdf);

    for (int i = 0; i < 4; i++) run(2'b10, 32'h400 + 32'h10 * i, 32'h200 + 6 * i, 1'b1, "R4");
    for (int i = 0; i < 4; i++) run(2'b11, '0, '0, 1'b1, "R5");
    check(result == 32'h200, "R5", "return order", result, 32'h200);

    run(2'b00, 32'hcafe_0001, '0, 1'b0, "R2", 1'b1);
    run(2'b10, 32'h0000_0800, 32'h0000_0123, 1'b0, "R4");
    run(2'b11, '0, '0, 1'b0, "R5");
    run(2'b01, '0, '0, 1'b0, "R3");

    run(2'b00, 32'h0000_0080, '0, 1'b0, "R6");
    run(2'b01, '0, '0, 1'b1, "R6");
    check(sp == 32'h80, "R6", "pointer loaded", sp, 32'h80);
    run(2'b00, 32'h0000_0102, '0, 1'b0, "R6");
    run(2'b01, '0, '0, 1'b1, "R6");
    for (int o = 0; o < 4; o++) run(2'(o), 32'h55, 32'h66, 1'b0, "R7");

    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    exp_sp = 32'h100; exp_res = '0;
    check(sp == 32'h100 && !err && result == 0, "R1", "reset clears", sp, 32'h100);
    rst_n = 1'b1;
    run(2'b00, 32'h0bad_beef, '0, 1'b0, "R2");
    run(2'b01, '0, '0, 1'b0, "R3");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule